// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block produces a serial test stream, one bit for each enabled transmit clock, for exercising and troubleshooting digital links. A single shift register of up to 32 stages serves two modes. In pseudorandom mode its last active stage and one programmable stage are combined by XOR to form the feedback. In repetitive mode the register rotates a user-loaded word of 1 to 32 bits.

Configuration is latched only on a load strobe. The latched items are the seed or word, the length, the second tap, the mode and the continuous error rate. After the strobe the new pattern starts on the next enabled clock. A disable input gaps the stream for fractional-rate or per-channel testing. Single bit errors can be injected on command. Continuous errors can be injected at a rate of one per 10^k enabled bits. Injected errors invert only the output bit and never disturb the generator.

Top module: `bitpat_gen`

## Requirements
- R1: In pseudorandom mode (cfg_rep=0), with latched length field L and tap field T (T<L), the output bit on each enabled clock is stage L of the register. On the same clock the register shifts one place toward higher stages and stage 0 takes stage L XOR stage T. Seed bit i loads stage i.
- R2: In repetitive mode (cfg_rep=1), with N=L+1, the output is cfg_word bits N-1 down to 0, most significant first, repeated without gaps. This holds for every N from 1 to 32.
- R3: A clock edge with load=1 latches all cfg_ inputs and restarts the generator, whatever the state of tx_dis. tx_bit reads 0 after that edge. The first bit of the new pattern appears on the first enabled edge that follows.
- R4: After reset, and until the first load, tx_bit stays 0.
- R5: An edge with tx_dis=1 and load=0 leaves tx_bit, the pattern position and the error-rate count unchanged.
- R6: An err_single pulse sampled on an edge inverts the output bit produced on the next enabled edge after it, however many disabled edges come between. The inversion happens exactly once.
- R7: With cfg_rate=k (1..7; 0 turns rate errors off) latched at load, exactly one output bit is inverted in every 10^k enabled clocks. The first inverted bit is the 10^k-th enabled bit after the load. Disabled clocks do not count.
- R8: In pseudorandom mode, a seed whose low N bits are all zero loads as all ones, so the sequence cannot lock at zero.
- R9: When a pending single error and a rate error fall on the same enabled clock, that bit is inverted once, not twice. The single request is consumed by that clock.
- R10: After any injected error, the uncorrupted pattern continues exactly as if no error had been inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Pseudorandom seed or repeating word |
| cfg_len | input | 5 | Pattern length minus one (L) |
| cfg_tap | input | 5 | Second feedback stage (T) for pseudorandom mode |
| cfg_rep | input | 1 | 1 selects repetitive mode, 0 pseudorandom |
| cfg_rate | input | 3 | Continuous error rate exponent k, 0 disables |
| load | input | 1 | Latches configuration and restarts the pattern |
| tx_dis | input | 1 | Suppresses shifting on this clock |
| err_single | input | 1 | Requests one inverted output bit |
| tx_bit | output | 1 | Serial test data |

## Verification
Two of the block's functions can hit the same enabled clock: the pending single-error request and the decade-rate error. The bench triggers both together. It loads a rate of one error in ten, pulses err_single on the ninth enabled clock, and expects the tenth bit to be inverted exactly once against an independent reference model. It then checks that the eleventh bit is clean, which shows that the request was consumed rather than carried over, and that the twentieth bit is inverted again by the rate alone.

// File: rtl/bitpat_gen.sv
module bitpat_gen #(
  parameter int W  = 32,
  parameter int CW = 24,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cfg_word,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_tap,
  input  logic          cfg_rep,
  input  logic [2:0]    cfg_rate,
  input  logic          load,
  input  logic          tx_dis,
  input  logic          err_single,
  output logic          tx_bit
);

  logic [W-1:0]  sr, mask, seed;
  logic [LW-1:0] len_q, tap_q;
  logic          rep_q, active, pend, tx_q;
  logic [2:0]    rate_q;
  logic [CW-1:0] cnt_q, lim;

  wire en  = active & ~tx_dis & ~load;
  wire fb  = rep_q ? sr[len_q] : (sr[len_q] ^ sr[tap_q]);
  wire hit = (rate_q != 3'd0) && (cnt_q == lim - 1'b1);
  wire inj = pend | hit;

  assign mask   = {W{1'b1}} >> (LW'(W - 1) - cfg_len);
  assign seed   = (!cfg_rep && ((cfg_word & mask) == '0)) ? {W{1'b1}} : cfg_word;
  assign tx_bit = tx_q;

  always_comb begin
    case (rate_q)
      3'd1:    lim = CW'(10);
      3'd2:    lim = CW'(100);
      3'd3:    lim = CW'(1000);
      3'd4:    lim = CW'(10000);
      3'd5:    lim = CW'(100000);
      3'd6:    lim = CW'(1000000);
      3'd7:    lim = CW'(10000000);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      len_q  <= '0;
      tap_q  <= '0;
      rep_q  <= 1'b0;
      rate_q <= '0;
      active <= 1'b0;
      tx_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      sr     <= seed;
      len_q  <= cfg_len;
      tap_q  <= cfg_tap;
      rep_q  <= cfg_rep;
      rate_q <= cfg_rate;
      active <= 1'b1;
      tx_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      tx_q <= sr[len_q] ^ inj;
      sr   <= {sr[W-2:0], fb};
      if (rate_q != 3'd0)
        cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= err_single | (pend & ~en);
  end

endmodule

// File: rtl/bitpat_gen_chk.sv
module bitpat_gen_chk #(
  parameter int W  = 32,
  parameter int CW = 24,
  localparam int LW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          tx_dis,
  input logic          err_single,
  input logic          tx_bit,
  input logic [W-1:0]  sr,
  input logic          active,
  input logic          pend,
  input logic          rep_q,
  input logic [LW-1:0] len_q,
  input logic [LW-1:0] tap_q,
  input logic [2:0]    rate_q,
  input logic [CW-1:0] cnt_q
);

  logic [W-1:0] lmask;
  assign lmask = {W{1'b1}} >> (LW'(W - 1) - len_q);

  a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tx_bit == 1'b0) && active);

  a_r4_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (tx_bit == 1'b0));

  a_r5_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dis && !load) |=> $stable(tx_bit) && $stable(sr) && $stable(cnt_q));

  a_r6_single_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && active && !tx_dis && !load && !err_single) |=> !pend);

  a_r7_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q != 3'd0) |-> (cnt_q < CW'(10000000)));

  a_r8_no_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rep_q && (tap_q < len_q)) |-> ((sr & lmask) != '0));

endmodule

bind bitpat_gen bitpat_gen_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .tx_dis(tx_dis),
  .err_single(err_single), .tx_bit(tx_bit), .sr(sr), .active(active),
  .pend(pend), .rep_q(rep_q), .len_q(len_q), .tap_q(tap_q),
  .rate_q(rate_q), .cnt_q(cnt_q)
);

// File: tb/sim_bitpat_gen.sv
module sim_bitpat_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [4:0]  cfg_len = '0;
  logic [4:0]  cfg_tap = '0;
  logic        cfg_rep = 1'b0;
  logic [2:0]  cfg_rate = '0;
  logic        load = 1'b0;
  logic        tx_dis = 1'b0;
  logic        err_single = 1'b0;
  logic        tx_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m;
  int ml, mt;
  bit mrep;

  bitpat_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_len(cfg_len),
    .cfg_tap(cfg_tap), .cfg_rep(cfg_rep), .cfg_rate(cfg_rate), .load(load),
    .tx_dis(tx_dis), .err_single(err_single), .tx_bit(tx_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic mstep(output logic b);
    logic f;
    b = m[ml];
    f = mrep ? b : (b ^ m[mt]);
    m = {m[30:0], f};
  endtask

  task automatic tick(input logic dis, input logic sgl, output logic b);
    tx_dis = dis;
    err_single = sgl;
    @(posedge clk);
    #1;
    err_single = 1'b0;
    b = tx_bit;
  endtask

  task automatic do_load(input logic [31:0] w, input int len, input int tap,
                         input bit rep, input int rate, input logic dis);
    logic [31:0] mk;
    cfg_word = w; cfg_len = 5'(len); cfg_tap = 5'(tap);
    cfg_rep = rep; cfg_rate = 3'(rate);
    tx_dis = dis; load = 1'b1;
    @(posedge clk);
    #1;
    load = 1'b0;
    chk("R3 output cleared by load", tx_bit, 1'b0);
    mk = (len == 31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 32'd1);
    ml = len; mt = tap; mrep = rep;
    m = (!rep && ((w & mk) == 32'd0)) ? 32'hFFFF_FFFF : w;
  endtask

  task automatic t_reset;
    logic b;
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R4 zero before first load", b, 1'b0);
    end
  endtask

  task automatic t_prbs;
    logic b, e;
    logic seq [254];
    do_load(32'h0000_005A, 6, 5, 0, 0, 1'b0);
    for (int i = 0; i < 254; i++) begin
      tick(1'b0, 1'b0, b);
      mstep(e);
      seq[i] = b;
      chk("R1 prbs7 bit", b, e);
    end
    for (int i = 0; i < 127; i++)
      chk("R1 prbs7 period 127", seq[i + 127], seq[i]);
    do_load(32'h0000_1234, 14, 13, 0, 0, 1'b0);
    for (int i = 0; i < 100; i++) begin
      tick(1'b0, 1'b0, b);
      mstep(e);
      chk("R1 prbs15 bit", b, e);
    end
  endtask

  task automatic t_zero_seed;
    logic b, e;
    int ones = 0;
    do_load(32'hFFFF_FE00, 8, 4, 0, 0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      tick(1'b0, 1'b0, b);
      mstep(e);
      ones += int'(b);
      chk("R8 zero seed runs as all ones", b, e);
    end
    chk("R8 stream not stuck at zero", logic'(ones > 0), 1'b1);
  endtask

  task automatic t_rep;
    logic b;
    logic [31:0] w;
    w = 32'h0000_0016;
    do_load(w, 4, 0, 1, 0, 1'b0);
    for (int i = 0; i < 15; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R2 5-bit word", b, w[4 - (i % 5)]);
    end
    do_load(32'h0000_0001, 0, 0, 1, 0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R2 1-bit word", b, 1'b1);
    end
    w = 32'hA5C3_0F96;
    do_load(w, 31, 0, 1, 0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R2 32-bit word", b, w[31 - (i % 32)]);
    end
    do_load(32'h0, 7, 0, 1, 0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R2 zero word stays zero", b, 1'b0);
    end
  endtask

  task automatic t_gap;
    logic b, e, prev;
    do_load(32'h0000_00C7, 8, 4, 0, 0, 1'b0);
    prev = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 1) begin
        tick(1'b1, 1'b0, b);
        chk("R5 held while disabled", b, prev);
      end else begin
        tick(1'b0, 1'b0, b);
        mstep(e);
        chk("R5 resumes pattern", b, e);
      end
      prev = b;
    end
  endtask

  task automatic t_single;
    logic b, e, prev;
    do_load(32'h0000_0033, 6, 5, 0, 0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0, b); mstep(e);
      chk("R6 clean before request", b, e);
    end
    tick(1'b0, 1'b1, b); mstep(e);
    chk("R6 request edge not inverted", b, e);
    prev = b;
    for (int i = 0; i < 2; i++) begin
      tick(1'b1, 1'b0, b);
      chk("R6 pending held across gap", b, prev);
    end
    tick(1'b0, 1'b0, b); mstep(e);
    chk("R6 inverted on next enabled", b, ~e);
    for (int i = 0; i < 20; i++) begin
      tick(1'b0, 1'b0, b); mstep(e);
      chk("R10 pattern intact after error", b, e);
    end
  endtask

  task automatic t_rate(input int rate, input int n, input int gap);
    logic b, e, dis;
    int en_cnt = 0;
    int per = 1;
    for (int k = 0; k < rate; k++) per *= 10;
    do_load(32'h0000_0101, 8, 4, 0, rate, 1'b0);
    for (int i = 0; i < n; i++) begin
      dis = (gap != 0) && (i % gap == gap - 1);
      tick(dis, 1'b0, b);
      if (!dis) begin
        en_cnt++;
        mstep(e);
        chk("R7 decade rate insertion", b, e ^ logic'(en_cnt % per == 0));
      end
    end
  endtask

  task automatic t_coincide;
    logic b, e;
    do_load(32'h0000_0055, 6, 5, 0, 1, 1'b0);
    for (int i = 1; i <= 20; i++) begin
      tick(1'b0, logic'(i == 9), b);
      mstep(e);
      if (i == 10)      chk("R9 single plus rate inverts once", b, ~e);
      else if (i == 20) chk("R9 rate alone after merge", b, ~e);
      else              chk("R9 request consumed, clean bit", b, e);
    end
  endtask

  task automatic t_reload;
    logic b, e;
    logic [31:0] w;
    do_load(32'h0000_0077, 6, 5, 0, 0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 1'b0, b); mstep(e);
      chk("R3 stream before reload", b, e);
    end
    w = 32'h0000_000D;
    do_load(w, 3, 0, 1, 0, 1'b1);
    tick(1'b1, 1'b0, b);
    chk("R3 no bit before first enabled edge", b, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 1'b0, b);
      chk("R3 new pattern after reload", b, w[3 - (i % 4)]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_prbs();
    t_zero_seed();
    t_rep();
    t_gap();
    t_single();
    t_rate(1, 45, 4);
    t_rate(2, 250, 0);
    t_rate(3, 1100, 7);
    t_coincide();
    t_reload();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule